// File: doc/BRIEF.md
# Windowed Positive-Peak Capture

This block watches a stream of signed samples and keeps the largest positive value seen since the last measurement window closed. When a window closes, that value is copied into a 12-bit result. The result counts in steps of 1/16 of a unit interval, peak to peak. It is split across two byte-wide read registers. At the same moment the tracker restarts from zero, so each result covers exactly one window.

Software ends a window in one of two ways. In manual mode it drives a stop bit from 0 to 1. In automatic mode a free-running cycle counter closes a window once per period; the default period is one second of a 125 MHz clock. A bandwidth-select bit is only stored and driven out to the sample source. The block does not produce the samples. A result that is not read before the next close is overwritten, and no flag records this.

Top module: `peak_window_capture`

## Requirements
- R1: The control register sits at address 0. Bit 0 is the bandwidth select and is driven on `bw_sel`. Bit 1 is the mode: 0 is manual, 1 is automatic. Bit 2 is the stop bit. Bits 7:3 ignore writes and read as 0.
- R2: In manual mode, a write that takes the stored stop bit from 0 to 1 at clock edge E closes the window. The result registers take the current peak at edge E+1 and change at no other time.
- R3: Writing 1 to the stop bit while it is already 1 does not close a window. The bit must first be written to 0.
- R4: While the mode bit is 1, the stop bit has no effect on the results.
- R5: In automatic mode a window closes every CYCLES_PER_WINDOW cycles. The counter restarts whenever the mode bit changes. A mode write at edge W gives the first update at edge W+1+CYCLES_PER_WINDOW.
- R6: Address 1 reads result bits 7:0. Address 2 reads result bits 11:8 in bits 3:0, with bits 7:4 as 0. Address 3 reads 0. Writes to addresses 1 to 3 are ignored.
- R7: After reset, every register reads 0x00 and `bw_sel` is 0.
- R8: A sample above 4095 counts as 4095. A negative sample never raises the peak.
- R9: At a close, the peak restarts from zero. A valid sample presented in the close cycle is left out of the closed result and seeds the next window.
- R10: A result that is not read is overwritten by the next close, and nothing records the loss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Signed two's-complement sample |
| bw_sel | output | 1 | Stored bandwidth-select bit |

## Verification
A stuck or stale stop-edge register shows at the next stop write. Either the results fail to update one cycle after the write, or they update on a repeated write of 1. A peak tracker that is not cleared, or that saturates wrongly, shows as a wrong value in the very next closed window. A period counter that is off by one, or that misses the restart on a mode change, moves the automatic update by a cycle. The bench therefore samples the result registers on both sides of the expected update edge.

// File: rtl/pkc_pkg.sv
package pkc_pkg;

  localparam int RES_W    = 12;
  localparam int RES_LO_W = 8;
  localparam int RES_HI_W = RES_W - RES_LO_W;
  localparam int BYTE_W   = 8;

  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_RES_LO = 2'd1,
    ADDR_RES_HI = 2'd2,
    ADDR_SPARE  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic stop;
    logic mode;
    logic bw;
  } ctrl_t;

endpackage

// File: rtl/pkc_reset_sync.sv
module pkc_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pkc_peak.sv
module pkc_peak
  import pkc_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                close,
  output logic [RES_W-1:0]    peak
);

  localparam logic [RES_W-1:0] SAT_MAX = '1;

  logic [RES_W-1:0] sat_val;
  logic [RES_W-1:0] peak_q;
  logic [RES_W-1:0] peak_d;
  logic             peak_en;

  // clamp: negative -> 0, above range -> all ones
  always_comb begin
    if (smp_data[SAMPLE_W-1])
      sat_val = '0;
    else if (|smp_data[SAMPLE_W-2:RES_W])
      sat_val = SAT_MAX;
    else
      sat_val = smp_data[RES_W-1:0];
  end

  always_comb begin
    peak_en = 1'b0;
    peak_d  = peak_q;
    if (close) begin
      peak_en = 1'b1;
      peak_d  = smp_valid ? sat_val : '0;
    end else if (smp_valid && (sat_val > peak_q)) begin
      peak_en = 1'b1;
      peak_d  = sat_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       peak_q <= '0;
    else if (peak_en) peak_q <= peak_d;
  end

  assign peak = peak_q;

  p_neg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_data[SAMPLE_W-1] && !close) |=> $stable(peak_q));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (close && !smp_valid) |=> (peak_q == '0));

endmodule

// File: rtl/pkc_window.sv
module pkc_window
  import pkc_pkg::*;
#(
  parameter int CYCLES_PER_WINDOW = 125_000_000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  ctrl_t ctrl,
  output logic  close
);

  localparam int CNT_W = (CYCLES_PER_WINDOW > 2) ? $clog2(CYCLES_PER_WINDOW) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CYCLES_PER_WINDOW - 1);

  logic             stop_q;
  logic             mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             close_man;
  logic             close_auto;

  always_comb begin
    close_man  = ctrl.stop && !stop_q && !ctrl.mode;
    close_auto = ctrl.mode && mode_q && (cnt_q == CNT_LAST);
    close      = close_man || close_auto;
  end

  always_comb begin
    if (!ctrl.mode || (ctrl.mode != mode_q))
      cnt_d = '0;
    else if (cnt_q == CNT_LAST)
      cnt_d = '0;
    else
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      mode_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      stop_q <= ctrl.stop;
      mode_q <= ctrl.mode;
      cnt_q  <= cnt_d;
    end
  end

  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.mode != mode_q) |=> (cnt_q == '0));

  p_single_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
    close |=> !close);

  p_stop_repeat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl.stop) && ctrl.stop && !ctrl.mode) |-> !close);

endmodule

// File: rtl/pkc_regs.sv
module pkc_regs
  import pkc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              close,
  input  logic [RES_W-1:0]  peak,
  output ctrl_t             ctrl
);

  ctrl_t            ctrl_q;
  ctrl_t            ctrl_d;
  logic             ctrl_en;
  logic [RES_W-1:0] res_q;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata[BYTE_W-1:3];

  always_comb begin
    ctrl_en = reg_wr && (reg_addr == ADDR_CTRL);
    ctrl_d  = '{stop: reg_wdata[2], mode: reg_wdata[1], bw: reg_wdata[0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     res_q <= '0;
    else if (close) res_q <= peak;
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_CTRL:   reg_rdata = {5'b0, ctrl_q.stop, ctrl_q.mode, ctrl_q.bw};
      ADDR_RES_LO: reg_rdata = res_q[RES_LO_W-1:0];
      ADDR_RES_HI: reg_rdata = {{(BYTE_W-RES_HI_W){1'b0}}, res_q[RES_W-1:RES_LO_W]};
      default:     reg_rdata = '0;
    endcase
  end

  assign ctrl = ctrl_q;

  p_result_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !close |=> $stable(res_q));

  p_result_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
    close |=> (res_q == $past(peak)));

endmodule

// File: rtl/peak_window_capture.sv
module peak_window_capture
  import pkc_pkg::*;
#(
  parameter int SAMPLE_W          = 16,
  parameter int CYCLES_PER_WINDOW = 125_000_000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          reg_addr,
  input  logic                reg_wr,
  input  logic [7:0]          reg_wdata,
  output logic [7:0]          reg_rdata,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic                bw_sel
);

  logic             rst_i_n;
  ctrl_t            ctrl;
  logic             close;
  logic [RES_W-1:0] peak;

  pkc_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  pkc_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .close     (close),
    .peak      (peak),
    .ctrl      (ctrl)
  );

  pkc_window #(.CYCLES_PER_WINDOW(CYCLES_PER_WINDOW)) u_win (
    .clk   (clk),
    .rst_n (rst_i_n),
    .ctrl  (ctrl),
    .close (close)
  );

  pkc_peak #(.SAMPLE_W(SAMPLE_W)) u_peak (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .close     (close),
    .peak      (peak)
  );

  assign bw_sel = ctrl.bw;

  p_ctrl_rsvd_r1: assert property (@(posedge clk) disable iff (!rst_i_n)
    (reg_addr == ADDR_CTRL) |-> (reg_rdata[7:3] == '0));

  p_hi_zero_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (reg_addr == ADDR_RES_HI) |-> (reg_rdata[7:4] == '0));

  p_auto_no_stop_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    ($rose(ctrl.stop) && ctrl.mode && $past(ctrl.mode)) |-> !u_win.close_man);

endmodule

// File: tb/peak_window_capture_tb_top.sv
module peak_window_capture_tb_top;

  localparam int SW = 16;
  localparam int T  = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    reg_addr;
  logic          reg_wr;
  logic [7:0]    reg_wdata;
  logic [7:0]    reg_rdata;
  logic          smp_valid;
  logic [SW-1:0] smp_data;
  logic          bw_sel;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int wcyc;
  int model_peak = 0;
  int last_res   = 0;
  int exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  peak_window_capture #(.SAMPLE_W(SW), .CYCLES_PER_WINDOW(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smp_valid(smp_valid),
    .smp_data(smp_data), .bw_sel(bw_sel)
  );

  function automatic int sat(input int v);
    if (v < 0) return 0;
    if (v > 4095) return 4095;
    return v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic send(input int v);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = SW'(v);
    @(negedge clk);
    smp_valid = 1'b0;
    if (sat(v) > model_peak) model_peak = sat(v);
  endtask

  // driver side: record expected result of a closing window
  task automatic push_close();
    exp_q.push_back(model_peak);
    model_peak = 0;
  endtask

  task automatic read_result(output int v);
    int lo, hi;
    rd(2'd1, lo);
    rd(2'd2, hi);
    v = (hi << 8) | lo;
  endtask

  // monitor side: pop and compare against the design's result registers
  task automatic monitor(input string req);
    int got, e;
    read_result(got);
    if (exp_q.size() == 0) begin
      chk({req, " queue empty"}, 1, 0);
    end else begin
      e = exp_q.pop_front();
      chk(req, got, e);
      last_res = e;
    end
  endtask

  task automatic expect_unchanged(input string req);
    int got;
    read_result(got);
    chk(req, got, last_res);
  endtask

  task automatic manual_close();
    wr(2'd0, 8'h04);
    @(negedge clk);
    push_close();
    wr(2'd0, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v;
    rst_n = 1'b0; reg_addr = 2'd0; reg_wr = 1'b0; reg_wdata = 8'h00;
    smp_valid = 1'b0; smp_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R7: reset state
    rd(2'd0, v); chk("R7 ctrl", v, 0);
    rd(2'd1, v); chk("R7 res_lo", v, 0);
    rd(2'd2, v); chk("R7 res_hi", v, 0);
    chk("R7 bw_sel", int'(bw_sel), 0);

    // R1: reserved bits, bandwidth export
    wr(2'd0, 8'hF9);
    rd(2'd0, v); chk("R1 ctrl readback", v, 8'h01);
    chk("R1 bw_sel", int'(bw_sel), 1);
    wr(2'd0, 8'h00);

    // R6: result registers are read-only, spare address reads 0
    wr(2'd1, 8'h5A); wr(2'd2, 8'h0F);
    rd(2'd1, v); chk("R6 lo write ignored", v, 0);
    rd(2'd2, v); chk("R6 hi write ignored", v, 0);
    rd(2'd3, v); chk("R6 spare", v, 0);

    // R2/R6: manual close, 3000 = 0xBB8 splits to lo 0xB8 hi 0x0B
    send(100); send(3000); send(-50); send(2000);
    wr(2'd0, 8'h04);
    expect_unchanged("R2 not before E+1");
    @(negedge clk);
    push_close();
    monitor("R2 manual close 3000");
    rd(2'd2, v); chk("R6 hi nibble", v, 8'h0B);

    // R3: repeated write of 1 does not close
    send(500);
    wr(2'd0, 8'h04);
    @(negedge clk);
    expect_unchanged("R3 repeat stop");
    wr(2'd0, 8'h00);
    manual_close();
    monitor("R3 close after clearing stop");

    // R8: saturation and negatives
    send(30000); send(12);
    manual_close();
    monitor("R8 saturate 4095");
    send(-5); send(-1000);
    manual_close();
    monitor("R8 negatives give 0");

    // R9: sample in close cycle seeds next window
    send(900);
    wr(2'd0, 8'h04);
    smp_valid = 1'b1; smp_data = SW'(777);
    @(negedge clk);
    smp_valid = 1'b0;
    push_close();
    model_peak = 777;
    monitor("R9 close excludes seed");
    wr(2'd0, 8'h00);
    send(300);
    manual_close();
    monitor("R9 seed in next window");

    // R5/R10: automatic period, overwrite without read
    wr(2'd0, 8'h02);
    wcyc = cyc;
    send(1500); send(40);
    while (cyc < wcyc + T) @(negedge clk);
    expect_unchanged("R5 no close at W+T");
    @(negedge clk);
    push_close();
    monitor("R5 first auto close");

    // R4: stop ignored in auto mode
    wr(2'd0, 8'h06);
    @(negedge clk);
    expect_unchanged("R4 stop in auto");
    send(60);
    while (cyc < wcyc + 2*T) @(negedge clk);
    expect_unchanged("R4 no early close");
    @(negedge clk);
    push_close();
    monitor("R4 second auto close");

    // R10: unread result replaced by the next close
    send(2222);
    while (cyc < wcyc + 3*T + 1) @(negedge clk);
    push_close();
    model_peak = 0;
    send(11);
    while (cyc < wcyc + 4*T + 1) @(negedge clk);
    push_close();
    void'(exp_q.pop_front());
    monitor("R10 overwritten");

    // R5: mode change restarts counter
    wr(2'd0, 8'h00);
    repeat (5) @(negedge clk);
    send(321);
    wr(2'd0, 8'h02);
    wcyc = cyc;
    while (cyc < wcyc + T) @(negedge clk);
    expect_unchanged("R5 restart no early close");
    @(negedge clk);
    push_close();
    monitor("R5 restart close");
    wr(2'd0, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule